// File: doc/BRIEF.md
# Transceiver Bring-Up Supervisor

This block supervises a transceiver reset controller during link start-up. After a configuration reset it stays idle. The first user reset-all pulse starts bring-up. The supervisor then waits for the transmit side to report reset completion, and after that for the receive side. Each wait is bounded by a programmable timeout. If a stage does not finish in time, the block issues a one-cycle request to the reset controller: a reset-all for the transmit stage, or a receive reset for the receive stage. It then starts the wait again.

Once both sides are up and the receive-data-good flag is high, the block raises its initialization-done flag. It keeps watching the receive-done and data-good inputs. If either drops, it lowers initialization-done, requests a receive reset and goes back to waiting on the receive side. Tying the data-good input high turns off these quality-driven retries.

A saturating retry counter records every reset request for debug. A user reset-all does not clear it; only the configuration reset does. A parameter selects whether the receive reset drives both the receive PLL request and the receive datapath request, or only the datapath request when one PLL serves both directions.

Top module: `xcvr_init_ctrl`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it is released, all request outputs, `init_done_o` and `retry_cnt_o` are 0.
- R2: Until the first user reset-all pulse after configuration reset, no reset request is issued and `init_done_o` stays 0, whatever the done and data-good inputs do.
- R3: While transmit done is low, `rst_all_o` pulses first at the TIMEOUT_CYC+2-th rising edge after the edge that samples the user pulse. It then pulses every TIMEOUT_CYC+1 cycles, and no receive reset is issued in this stage.
- R4: When transmit done is high, the receive wait lasts TIMEOUT_CYC+1 cycles. At its end, if receive done and data good are both high, `init_done_o` rises; otherwise a receive reset pulse is issued and the wait restarts. With all inputs already high, `init_done_o` rises at the TIMEOUT_CYC+3-th edge after the user pulse edge.
- R5: After initialization, a drop of receive done or data good is acted on at the third rising edge after the input changes. At that edge `init_done_o` falls, one receive reset pulse is issued, and the receive wait restarts.
- R6: Every reset request is exactly one cycle wide. Each request increments the retry count in the same cycle it appears.
- R7: The retry count saturates at RETRY_MAX and never wraps.
- R8: A user reset-all does not change the retry count; only `rst_ni` clears it.
- R9: A user reset-all in any state clears `init_done_o` at the sampling edge and restarts bring-up from the start state.
- R10: With SHARED_PLL = 0, `rx_pll_rst_o` and `rx_dp_rst_o` pulse together. With SHARED_PLL = 1, only `rx_dp_rst_o` pulses and `rx_pll_rst_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Configuration/power-on reset, active low, asynchronous |
| user_rst_all_i | input | 1 | User reset-all pulse, synchronous to clk_i |
| tx_done_i | input | 1 | Transmit reset complete, asynchronous |
| rx_done_i | input | 1 | Receive reset complete, asynchronous |
| rx_data_good_i | input | 1 | Receive data quality good, asynchronous |
| rst_all_o | output | 1 | Reset-all request pulse to the reset controller |
| rx_pll_rst_o | output | 1 | Receive PLL reset request pulse |
| rx_dp_rst_o | output | 1 | Receive datapath reset request pulse |
| init_done_o | output | 1 | Bring-up complete and link healthy |
| retry_cnt_o | output | $clog2(RETRY_MAX+1) | Saturating count of reset requests |

## Verification
The bench measures the exact edge at which the first timeout request appears, and the spacing between repeated requests. An off-by-one in the timer or in the synchronizer depth would shift these by a cycle. It drives the retry count past RETRY_MAX, where a counter without saturation would wrap to a small value. It also applies user resets with a non-zero count, which a design that clears on user reset would lose. The bench drops data good for exactly two and then three cycles, which catches a design that ignores the synchronizer latency or never leaves the monitor state. A second instance with a shared PLL catches a PLL request that leaks through.

// File: rtl/xcvr_init_pkg.sv
package xcvr_init_pkg;
  typedef enum logic [1:0] {
    ST_START   = 2'd0,
    ST_TX_WAIT = 2'd1,
    ST_RX_WAIT = 2'd2,
    ST_RX_MON  = 2'd3
  } init_state_e;
endpackage

// File: rtl/xcvr_init_sync.sv
module xcvr_init_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/xcvr_init_timer.sv
module xcvr_init_timer #(
  parameter int unsigned TIMEOUT_CYC = 1000,
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic expired_o
);
  logic [TW-1:0] cnt_q;

  assign expired_o = (cnt_q == TW'(TIMEOUT_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (inc_i && !expired_o) cnt_q <= cnt_q + TW'(1);
  end

  assert_timer_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TW'(TIMEOUT_CYC));
  assert_timer_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/xcvr_init_retry.sv
module xcvr_init_retry #(
  parameter int unsigned RETRY_MAX = 255,
  localparam int unsigned CNT_W = $clog2(RETRY_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             sat;

  assign sat   = (cnt_q == CNT_W'(RETRY_MAX));
  assign cnt_o = cnt_q;

  // only configuration reset clears the count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (inc_i && !sat) cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(RETRY_MAX));
  assert_count_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> (cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == CNT_W'(RETRY_MAX)));
  assert_count_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/xcvr_init_fsm.sv
module xcvr_init_fsm
  import xcvr_init_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic user_rst_i,
  input  logic tx_done_i,
  input  logic rx_done_i,
  input  logic rx_good_i,
  input  logic expired_i,
  output logic timer_clr_o,
  output logic timer_inc_o,
  output logic retry_inc_o,
  output logic rst_all_o,
  output logic rx_rst_o,
  output logic init_done_o
);
  init_state_e state_q, state_d;
  logic armed_q, armed_d;
  logic done_q, done_d;
  logic rst_all_q, rst_all_d;
  logic rx_rst_q, rx_rst_d;
  logic rx_ok;

  assign rx_ok = rx_done_i && rx_good_i;

  always_comb begin
    state_d     = state_q;
    armed_d     = armed_q;
    done_d      = done_q;
    rst_all_d   = 1'b0;
    rx_rst_d    = 1'b0;
    timer_clr_o = 1'b0;
    timer_inc_o = 1'b0;
    retry_inc_o = 1'b0;
    if (user_rst_i) begin
      state_d     = ST_START;
      armed_d     = 1'b1;
      done_d      = 1'b0;
      timer_clr_o = 1'b1;
    end else begin
      unique case (state_q)
        ST_START: begin
          if (armed_q) begin
            state_d     = ST_TX_WAIT;
            timer_clr_o = 1'b1;
          end
        end
        ST_TX_WAIT: begin
          if (tx_done_i) begin
            state_d     = ST_RX_WAIT;
            timer_clr_o = 1'b1;
          end else if (expired_i) begin
            timer_clr_o = 1'b1;
            rst_all_d   = 1'b1;
            retry_inc_o = 1'b1;
          end else begin
            timer_inc_o = 1'b1;
          end
        end
        ST_RX_WAIT: begin
          if (!expired_i) begin
            timer_inc_o = 1'b1;
          end else if (rx_ok) begin
            state_d     = ST_RX_MON;
            done_d      = 1'b1;
            timer_clr_o = 1'b1;
          end else begin
            timer_clr_o = 1'b1;
            rx_rst_d    = 1'b1;
            retry_inc_o = 1'b1;
          end
        end
        ST_RX_MON: begin
          if (!rx_ok) begin
            state_d     = ST_RX_WAIT;
            done_d      = 1'b0;
            timer_clr_o = 1'b1;
            rx_rst_d    = 1'b1;
            retry_inc_o = 1'b1;
          end
        end
        default: state_d = ST_START;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_START;
      armed_q   <= 1'b0;
      done_q    <= 1'b0;
      rst_all_q <= 1'b0;
      rx_rst_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      armed_q   <= armed_d;
      done_q    <= done_d;
      rst_all_q <= rst_all_d;
      rx_rst_q  <= rx_rst_d;
    end
  end

  assign rst_all_o   = rst_all_q;
  assign rx_rst_o    = rx_rst_q;
  assign init_done_o = done_q;

  assert_single_rst_all_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_all_q |=> !rst_all_q);
  assert_single_rx_rst_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rst_q |=> !rx_rst_q);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !user_rst_i) |=> (!rst_all_q && !rx_rst_q && !done_q));
  assert_done_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> ($past(state_q) == ST_RX_WAIT));
  assert_rx_rst_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rst_q |-> ($past(state_q) == ST_RX_WAIT || $past(state_q) == ST_RX_MON));
  assert_user_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    user_rst_i |=> (!done_q && state_q == ST_START));
  assert_tx_rst_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_all_q |-> ($past(state_q) == ST_TX_WAIT));
endmodule

// File: rtl/xcvr_init_ctrl.sv
module xcvr_init_ctrl #(
  parameter int unsigned TIMEOUT_CYC = 1000,
  parameter int unsigned RETRY_MAX   = 255,
  parameter bit          SHARED_PLL  = 1'b0,
  localparam int unsigned CNT_W = $clog2(RETRY_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             user_rst_all_i,
  input  logic             tx_done_i,
  input  logic             rx_done_i,
  input  logic             rx_data_good_i,
  output logic             rst_all_o,
  output logic             rx_pll_rst_o,
  output logic             rx_dp_rst_o,
  output logic             init_done_o,
  output logic [CNT_W-1:0] retry_cnt_o
);
  logic [2:0] sync_q;
  logic timer_clr, timer_inc, expired, retry_inc, rx_rst;

  xcvr_init_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rx_data_good_i, rx_done_i, tx_done_i}),
    .q_o   (sync_q)
  );

  xcvr_init_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (timer_clr),
    .inc_i    (timer_inc),
    .expired_o(expired)
  );

  xcvr_init_retry #(.RETRY_MAX(RETRY_MAX)) u_retry (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (retry_inc),
    .cnt_o (retry_cnt_o)
  );

  xcvr_init_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .user_rst_i (user_rst_all_i),
    .tx_done_i  (sync_q[0]),
    .rx_done_i  (sync_q[1]),
    .rx_good_i  (sync_q[2]),
    .expired_i  (expired),
    .timer_clr_o(timer_clr),
    .timer_inc_o(timer_inc),
    .retry_inc_o(retry_inc),
    .rst_all_o  (rst_all_o),
    .rx_rst_o   (rx_rst),
    .init_done_o(init_done_o)
  );

  assign rx_dp_rst_o = rx_rst;
  if (SHARED_PLL) begin : g_shared_pll
    assign rx_pll_rst_o = 1'b0;
  end else begin : g_split_pll
    assign rx_pll_rst_o = rx_rst;
  end
endmodule

// File: tb/xcvr_init_ctrl_bench.sv
module xcvr_init_ctrl_bench;
  localparam int TMO  = 8;
  localparam int RMAX = 5;
  localparam int CW   = $clog2(RMAX + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic usr = 1'b0, tx = 1'b0, rx = 1'b0, good = 1'b0;
  logic rst_all, rx_pll, rx_dp, done;
  logic rst_all_s, rx_pll_s, rx_dp_s, done_s;
  logic [CW-1:0] retry, retry_s;

  int n_chk = 0, n_bad = 0;
  int c_rst_all = 0, c_rx_pll = 0, c_rx_dp = 0, c_rx_pll_s = 0, c_rx_dp_s = 0, width_bad = 0;
  logic p_rst_all = 0, p_rx_dp = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xcvr_init_ctrl #(.TIMEOUT_CYC(TMO), .RETRY_MAX(RMAX), .SHARED_PLL(1'b0)) u_xcvr_init_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .user_rst_all_i(usr), .tx_done_i(tx), .rx_done_i(rx),
    .rx_data_good_i(good), .rst_all_o(rst_all), .rx_pll_rst_o(rx_pll), .rx_dp_rst_o(rx_dp),
    .init_done_o(done), .retry_cnt_o(retry));

  xcvr_init_ctrl #(.TIMEOUT_CYC(TMO), .RETRY_MAX(RMAX), .SHARED_PLL(1'b1)) u_xcvr_init_ctrl_shared (
    .clk_i(clk), .rst_ni(rst_n), .user_rst_all_i(usr), .tx_done_i(tx), .rx_done_i(rx),
    .rx_data_good_i(good), .rst_all_o(rst_all_s), .rx_pll_rst_o(rx_pll_s), .rx_dp_rst_o(rx_dp_s),
    .init_done_o(done_s), .retry_cnt_o(retry_s));

  // pulse bookkeeping, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_all) c_rst_all++;
    if (rx_pll) c_rx_pll++;
    if (rx_dp) c_rx_dp++;
    if (rx_pll_s) c_rx_pll_s++;
    if (rx_dp_s) c_rx_dp_s++;
    if ((rst_all && p_rst_all) || (rx_dp && p_rx_dp)) width_bad++;
    p_rst_all = rst_all;
    p_rx_dp   = rx_dp;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_user();
    usr = 1'b1;
    @(negedge clk);
    usr = 1'b0;
  endtask

  task automatic cfg_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic sig(input int which);
    case (which)
      0: return rst_all;
      1: return rx_dp;
      default: return done;
    endcase
  endfunction

  task automatic wait_sig(input int which, inout int n);
    while (!sig(which) && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  typedef struct packed {
    logic       u;
    logic       t;
    logic       r;
    logic       g;
    logic [7:0] cyc;
    logic       exp_done;
    logic [7:0] exp_retry;
    logic [3:0] req;
  } step_t;

  localparam int NSTEP = 11;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'd30, 1'b0, 8'd0, 4'd2},  // idle, no user pulse yet
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'd30, 1'b1, 8'd0, 4'd4},  // bring-up, clean
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'd2,  1'b1, 8'd0, 4'd5},  // good low, still in sync chain
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'd1,  1'b0, 8'd1, 4'd5},  // third edge acts
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'd30, 1'b1, 8'd1, 4'd5},  // recovers
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'd3,  1'b0, 8'd2, 4'd5},  // rx done lost
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'd30, 1'b1, 8'd2, 4'd4},
    '{1'b1, 1'b1, 1'b1, 1'b1, 8'd2,  1'b0, 8'd2, 4'd9},  // user reset while up
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'd30, 1'b1, 8'd2, 4'd8},
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'd3,  1'b0, 8'd3, 4'd5},
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'd30, 1'b0, 8'd5, 4'd7}   // repeated retries saturate
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    int snap_a, snap_b, snap_c;
    repeat (3) @(negedge clk);
    check(rst_all == 0 && rx_pll == 0 && rx_dp == 0 && done == 0, "R1 outputs under reset",
          {rst_all, rx_pll, rx_dp, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(retry == 0 && done == 0 && rst_all == 0, "R1 state after release", retry, 0);

    for (int i = 0; i < NSTEP; i++) begin
      usr = STEPS[i].u; tx = STEPS[i].t; rx = STEPS[i].r; good = STEPS[i].g;
      @(negedge clk);
      usr = 1'b0;
      for (int c = 1; c < int'(STEPS[i].cyc); c++) @(negedge clk);
      check(done == STEPS[i].exp_done, $sformatf("R%0d step %0d init_done", STEPS[i].req, i),
            done, STEPS[i].exp_done);
      check(retry == CW'(STEPS[i].exp_retry), $sformatf("R%0d step %0d retry", STEPS[i].req, i),
            retry, STEPS[i].exp_retry);
    end

    // R3: transmit timeout timing and spacing
    tx = 0; rx = 0; good = 0;
    cfg_reset();
    repeat (3) @(negedge clk);
    check(retry == 0 && rst_all == 0, "R2 idle after cfg reset", retry, 0);
    snap_b = c_rx_dp;
    pulse_user();
    n = 1;
    wait_sig(0, n);
    check(n == TMO + 3, "R3 first reset-all edge", n, TMO + 3);
    check(retry == 1, "R6 retry counts reset-all", retry, 1);
    @(negedge clk);
    n = 1;
    wait_sig(0, n);
    check(n == TMO + 1, "R3 reset-all spacing", n, TMO + 1);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      n = 1;
      wait_sig(0, n);
    end
    check(retry == RMAX, "R7 saturation on tx retries", retry, RMAX);
    check(c_rx_dp == snap_b, "R3 no rx reset during tx wait", c_rx_dp - snap_b, 0);

    // R8: user reset keeps count; config reset clears it
    pulse_user();
    check(retry == RMAX && done == 0, "R8 user reset keeps retry", retry, RMAX);
    cfg_reset();
    check(retry == 0, "R8 cfg reset clears retry", retry, 0);

    // R4/R10: receive timeout path
    tx = 1; rx = 0; good = 1;
    repeat (4) @(negedge clk);
    snap_a = c_rst_all;
    pulse_user();
    n = 1;
    wait_sig(1, n);
    check(n == TMO + 4, "R4 first rx reset edge", n, TMO + 4);
    check(rx_pll == 1 && rx_dp == 1, "R10 split pll both pulse", {rx_pll, rx_dp}, 3);
    check(rx_dp_s == 1 && rx_pll_s == 0, "R10 shared pll datapath only", {rx_pll_s, rx_dp_s}, 1);
    @(negedge clk);
    n = 1;
    wait_sig(1, n);
    check(n == TMO + 1, "R4 rx reset spacing", n, TMO + 1);
    check(retry == 2, "R6 retry counts rx resets", retry, 2);
    check(c_rst_all == snap_a, "R4 no reset-all in rx wait", c_rst_all - snap_a, 0);

    // R4/R9: exact bring-up latency after user reset
    rx = 1;
    repeat (20) @(negedge clk);
    check(done == 1 && retry == 2, "R4 recovery to done", {done, 1'b0} | retry, 2);
    pulse_user();
    check(done == 0, "R9 user reset clears done", done, 0);
    n = 1;
    wait_sig(2, n);
    check(n == TMO + 4, "R4 init_done edge", n, TMO + 4);
    check(retry == 2, "R8 retry unchanged by user reset", retry, 2);

    @(negedge clk);
    check(c_rx_pll_s == 0, "R10 shared pll request never", c_rx_pll_s, 0);
    check(c_rx_pll == c_rx_dp, "R10 split pll tracks datapath", c_rx_pll, c_rx_dp);
    check(c_rx_dp_s == c_rx_dp, "R10 shared datapath count", c_rx_dp_s, c_rx_dp);
    check(width_bad == 0, "R6 pulse width one cycle", width_bad, 0);
    finish_run();
  end
endmodule